// File: doc/BRIEF.md
# Bit-Serial Fixed-Point Reciprocal Unit

This block computes the fixed-point reciprocal of an unsigned integer operand, producing one result bit per clock and using no multiplier. The result is the largest `WIDTH`-bit value whose product with the operand does not exceed 2^`WIDTH`. In other words, it is 2^`WIDTH` divided by the operand, saturated to all ones.

A run starts on a one-cycle strobe that captures the operand. The unit then tries result bits from the most significant bit down. It keeps a running product of the accepted result times the operand. Each cycle it adds one pre-shifted copy of the operand to that product to form a trial value. It keeps the trial bit only if the trial value stays at or below the fixed-point one.

After `WIDTH` iterations the unit raises a one-cycle completion pulse. The result stays on the output until the next accepted run.

Top module: `recip_serial_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o` is 0 and `result_o` is 0 until a run completes.
- R2: A start is accepted when `start_i` is sampled high while the unit is idle. `done_o` is high in the cycle after the `WIDTH`-th rising edge that follows the accepting edge.
- R3: For an operand x > 0, the completed `result_o` equals min(floor(2^WIDTH / x), 2^WIDTH − 1). This is the largest `WIDTH`-bit value a with a·x ≤ 2^WIDTH.
- R4: An operand of zero yields a result of all ones.
- R5: An operand of 1 yields all ones. An operand of 2^k with k ≥ 1 yields exactly 2^(WIDTH−k).
- R6: While idle, `result_o` holds the last completed result.
- R7: During a run, `start_i` pulses and changes on `operand_i` have no effect. The result and the completion time depend only on the operand captured at the accepting edge.
- R8: `done_o` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| operand_i | input | WIDTH | Unsigned operand, captured with an accepted start |
| result_o | output | WIDTH | Fixed-point reciprocal |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with `WIDTH` = 8. At that width every operand from 0 to 255 can be applied, so the saturated region, the zero operand, every power of two and every truncation case are covered exhaustively. The timing of the completion pulse is measured on each run. A separate run issues a second start and a new operand in the middle of an iteration sequence, and the hold of the result across idle cycles is checked afterwards.

// File: rtl/recip_pkg.sv
package recip_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } recip_state_e;
endpackage

// File: rtl/recip_ctrl.sv
module recip_ctrl
  import recip_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  recip_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_run_ignores_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_done_ends_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_RUN && $past(cnt_q) == LAST));
endmodule

// File: rtl/recip_datapath.sv
module recip_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] approx_o
);
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] FIX_ONE = {{(WIDTH-1){1'b0}}, 1'b1, {WIDTH{1'b0}}};

  logic [WIDTH-1:0] approx_q, bit_q;
  logic [PW-1:0]    run_q, part_q, trial_prod;
  logic             accept;

  // one added partial product replaces a full multiply per step
  assign trial_prod = run_q + part_q;
  assign accept     = (trial_prod <= FIX_ONE);
  assign approx_o   = approx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      approx_q <= '0;
      run_q    <= '0;
      bit_q    <= '0;
      part_q   <= '0;
    end else if (load_i) begin
      approx_q <= '0;
      run_q    <= '0;
      bit_q    <= {1'b1, {(WIDTH-1){1'b0}}};
      part_q   <= {1'b0, operand_i, {(WIDTH-1){1'b0}}};
    end else if (step_i) begin
      if (accept) begin
        approx_q <= approx_q | bit_q;
        run_q    <= trial_prod;
      end
      bit_q  <= bit_q >> 1;
      part_q <= part_q >> 1;
    end
  end

  p_product_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= FIX_ONE);

  p_approx_grows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> approx_q >= $past(approx_q));

  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(approx_q));
endmodule

// File: rtl/recip_serial_unit.sv
module recip_serial_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  logic load, step;

  recip_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .done_o (done_o)
  );

  recip_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .operand_i(operand_i),
    .approx_o (result_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!done_o && result_o == '0));
endmodule

// File: tb/recip_serial_unit_tb.sv
module recip_serial_unit_tb;
  localparam int W = 8;
  localparam longint ONE = 64'sd1 << W;

  typedef struct {
    logic [W-1:0] exp;
    logic [W-1:0] opnd;
    int           start_edge;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] operand_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  item_t sb_q[$];
  logic [W-1:0] last_exp = '0;

  recip_serial_unit #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .operand_i(operand_i), .result_o(result_o), .done_o(done_o)
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [W-1:0] ref_recip(input longint x);
    longint q;
    if (x == 0) return {W{1'b1}};
    q = ONE / x;
    if (q > ONE - 1) q = ONE - 1;
    return q[W-1:0];
  endfunction

  function automatic bit is_pow2(input logic [W-1:0] x);
    return (x != 0) && ((x & (x - 1'b1)) == 0);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    item_t it;
    while (sb_q.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
    check(done_o == 1'b0, "R8", done_o, 0);
  endtask

  task automatic run_op(input logic [W-1:0] x);
    item_t it;
    @(negedge clk_i);
    operand_i = x;
    start_i   = 1'b1;
    it.exp = ref_recip(longint'(x));
    it.opnd = x;
    it.start_edge = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk_i);
    start_i = 1'b0;
    finish_run();
  endtask

  // monitor: pops one expected item per completion pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8", 1, 0);
      end else begin
        item_t it;
        string tag;
        it = sb_q.pop_front();
        if (it.opnd == 0) tag = "R4";
        else if (is_pow2(it.opnd)) tag = "R5";
        else tag = "R3";
        check(result_o == it.exp, tag, result_o, it.exp);
        check(cyc - it.start_edge == W, "R2", cyc - it.start_edge, W);
        last_exp = it.exp;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "R2 watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R1", done_o, 0);
    check(result_o == '0, "R1", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(done_o == 1'b0 && result_o == '0, "R1", result_o, 0);

    // exhaustive operands: R3, R4 (zero), R5 (powers of two)
    for (int x = 0; x < (1 << W); x++) run_op(W'(x));

    // R7: mid-run restart attempt and operand change are ignored
    @(negedge clk_i);
    operand_i = W'(3);
    start_i = 1'b1;
    it.exp = ref_recip(3);
    it.opnd = W'(3);
    it.start_edge = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk_i);
    start_i = 1'b0;
    operand_i = W'(200);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    finish_run();
    check(last_exp == ref_recip(3), "R7", last_exp, ref_recip(3));

    // R6: result holds while idle, operand changes notwithstanding
    for (int k = 0; k < 6; k++) begin
      operand_i = W'(k * 37);
      @(negedge clk_i);
      check(result_o == ref_recip(3), "R6", result_o, ref_recip(3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule